// File: doc/BRIEF.md
# Lockable Dual-Master Shared RAM

This block is a single-clock word memory reached through two access ports. One port serves hardware logic and the other serves a host or software bus. A build-time parameter picks one of two modes. In lockable mode a hardware mutex guards the array, and a port may read or write only while it owns the lock. In unprotected mode both ports may read and write at any time.

Each port has a plain access strobe with a write-enable, an address, write data and registered read data. It also has a lock request pulse, a lock release pulse, a level that shows it owns the lock, and a one-cycle flag that marks a refused access. The ports carry no valid/ready handshake. Every access strobe is taken in the cycle it is presented, and its result appears one cycle later. So no back-pressure is ever applied, and the caller must hold off by itself until it sees the grant level.

Top module: `shared_lock_ram`

## Requirements
- R1: After reset the lock is free. Both grant outputs, both denied flags and both read-data outputs are 0.
- R2: In lockable mode, a lock request made while the lock is free makes that port's grant output 1 after the next clock edge. The grant stays 1 until that same port pulses release. After that edge the lock is free again. The two grant outputs are never 1 together.
- R3: In lockable mode, if both ports request the lock in the same cycle while it is free, the hardware port receives it.
- R4: While the hardware port owns the lock, a software-port access is refused. Its write leaves the array unchanged, its read data after the next edge is 0, and its denied flag is 1 for exactly the cycle after each refused access.
- R5: While the software port owns the lock, a hardware-port access is refused in the same way: no write, read data 0, and a one-cycle denied flag.
- R6: In lockable mode, while the lock is free, an access from either port is refused in the same way.
- R7: A release pulse from the port that does not own the lock has no effect. A lock request while the other port owns the lock is dropped and is not queued, so after the owner releases, the lock is free.
- R8: A granted read (strobe 1, write-enable 0) returns the addressed word on that port's read data after the next edge. In a cycle that follows no accepted read, the read data is 0.
- R9: In unprotected mode the lock inputs are ignored. Both grant outputs stay 0, the denied flags never rise, and both ports may read and write freely.
- R10: In unprotected mode, when both ports write the same address in the same cycle, the hardware port's data is stored.
- R11: A read on one port in the same cycle as a write to that address from the other port returns the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware port access strobe |
| hw_we | input | 1 | Hardware port write (1) or read (0) |
| hw_addr | input | ADDR_W | Hardware port word address |
| hw_wdata | input | DATA_W | Hardware port write data |
| hw_rdata | output | DATA_W | Hardware port read data, one cycle after the strobe |
| hw_lock_req | input | 1 | Hardware port lock request |
| hw_lock_rel | input | 1 | Hardware port lock release |
| hw_granted | output | 1 | Hardware port owns the lock |
| hw_denied | output | 1 | Hardware access refused in the previous cycle |
| sw_en | input | 1 | Software port access strobe |
| sw_we | input | 1 | Software port write (1) or read (0) |
| sw_addr | input | ADDR_W | Software port word address |
| sw_wdata | input | DATA_W | Software port write data |
| sw_rdata | output | DATA_W | Software port read data, one cycle after the strobe |
| sw_lock_req | input | 1 | Software port lock request |
| sw_lock_rel | input | 1 | Software port lock release |
| sw_granted | output | 1 | Software port owns the lock |
| sw_denied | output | 1 | Software access refused in the previous cycle |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This holds for a change of grant after a request or release, for read data after a read strobe, and for the denied flag after a refused access. The bench changes inputs just after a falling edge and samples outputs at the next falling edge, so exactly one rising edge lies between stimulus and check. It then drives one idle cycle and samples again, to confirm that the denied flag falls back and that the read data returns to 0. Refused writes are checked only at the ports, by a later granted read of the same address.

// File: rtl/shared_lock_ram_pkg.sv
package shared_lock_ram_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HW   = 2'd1,
    OWN_SW   = 2'd2
  } owner_e;
endpackage

// File: rtl/srm_lock_arb.sv
module srm_lock_arb
  import shared_lock_ram_pkg::*;
#(
  parameter bit LOCKABLE = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hw_req,
  input  logic   hw_rel,
  input  logic   sw_req,
  input  logic   sw_rel,
  output owner_e owner
);
  generate
    if (LOCKABLE) begin : g_mutex
      owner_e owner_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          owner_q <= OWN_NONE;
        end else begin
          unique case (owner_q)
            OWN_NONE: begin
              // hardware side wins a same-cycle tie
              if (hw_req)      owner_q <= OWN_HW;
              else if (sw_req) owner_q <= OWN_SW;
            end
            OWN_HW:  if (hw_rel) owner_q <= OWN_NONE;
            OWN_SW:  if (sw_rel) owner_q <= OWN_NONE;
            default: owner_q <= OWN_NONE;
          endcase
        end
      end

      assign owner = owner_q;

      p_tie_hw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_NONE && hw_req && sw_req) |=> (owner_q == OWN_HW));
      p_hw_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_HW && !hw_rel) |=> (owner_q == OWN_HW));
      p_sw_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_SW && !sw_rel) |=> (owner_q == OWN_SW));
      p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((owner_q == OWN_HW && hw_rel) || (owner_q == OWN_SW && sw_rel))
        |=> (owner_q == OWN_NONE));
    end else begin : g_open
      assign owner = OWN_NONE;
    end
  endgenerate
endmodule

// File: rtl/srm_port_gate.sv
module srm_port_gate
  import shared_lock_ram_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit LOCKABLE = 1'b1,
  parameter bit IS_HW    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  owner_e            owner,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr_ok,
  output logic [DATA_W-1:0] rd_data,
  output logic              denied
);
  localparam owner_e MY_ID = IS_HW ? OWN_HW : OWN_SW;

  logic allowed;
  assign allowed = !LOCKABLE || (owner == MY_ID);
  assign wr_ok   = en && we && allowed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      denied  <= 1'b0;
    end else begin
      denied  <= en && !allowed;
      rd_data <= (en && !we && allowed) ? mem_rdata : '0;
    end
  end

  p_deny_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    denied |-> (rd_data == '0));
  p_deny_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    denied |-> $past(en));

  generate
    if (!LOCKABLE) begin : g_open_chk
      p_never_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !denied);
    end
  endgenerate
endmodule

// File: rtl/srm_mem.sv
module srm_mem #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // port A is written last so it wins a same-address collision
  always_ff @(posedge clk) begin
    if (b_we) store[b_addr] <= b_wdata;
    if (a_we) store[a_addr] <= a_wdata;
  end

  assign a_rdata = store[a_addr];
  assign b_rdata = store[b_addr];

  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we && a_addr == b_addr) |=> (store[$past(a_addr)] == $past(a_wdata)));
endmodule

// File: rtl/shared_lock_ram.sv
module shared_lock_ram
  import shared_lock_ram_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter bit LOCKABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic              hw_we,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [DATA_W-1:0] hw_wdata,
  output logic [DATA_W-1:0] hw_rdata,
  input  logic              hw_lock_req,
  input  logic              hw_lock_rel,
  output logic              hw_granted,
  output logic              hw_denied,
  input  logic              sw_en,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata,
  input  logic              sw_lock_req,
  input  logic              sw_lock_rel,
  output logic              sw_granted,
  output logic              sw_denied
);
  owner_e            owner;
  logic              hw_wr, sw_wr;
  logic [DATA_W-1:0] hw_mem_q, sw_mem_q;

  srm_lock_arb #(.LOCKABLE(LOCKABLE)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .hw_req(hw_lock_req), .hw_rel(hw_lock_rel),
    .sw_req(sw_lock_req), .sw_rel(sw_lock_rel),
    .owner(owner)
  );

  srm_port_gate #(.DATA_W(DATA_W), .LOCKABLE(LOCKABLE), .IS_HW(1'b1)) u_hw_gate (
    .clk(clk), .rst_n(rst_n), .en(hw_en), .we(hw_we), .owner(owner),
    .mem_rdata(hw_mem_q), .wr_ok(hw_wr), .rd_data(hw_rdata), .denied(hw_denied)
  );

  srm_port_gate #(.DATA_W(DATA_W), .LOCKABLE(LOCKABLE), .IS_HW(1'b0)) u_sw_gate (
    .clk(clk), .rst_n(rst_n), .en(sw_en), .we(sw_we), .owner(owner),
    .mem_rdata(sw_mem_q), .wr_ok(sw_wr), .rd_data(sw_rdata), .denied(sw_denied)
  );

  srm_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .a_we(hw_wr), .a_addr(hw_addr), .a_wdata(hw_wdata),
    .b_we(sw_wr), .b_addr(sw_addr), .b_wdata(sw_wdata),
    .a_rdata(hw_mem_q), .b_rdata(sw_mem_q)
  );

  assign hw_granted = (owner == OWN_HW);
  assign sw_granted = (owner == OWN_SW);

  p_excl_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hw_granted, sw_granted}));
  p_sw_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_granted && sw_en) |=> sw_denied);
  p_hw_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_granted && hw_en) |=> hw_denied);
endmodule

// File: tb/shared_lock_ram_tb_top.sv
module shared_lock_ram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_en = 0, h_we = 0, h_lreq = 0, h_lrel = 0;
  logic s_en = 0, s_we = 0, s_lreq = 0, s_lrel = 0;
  logic [AW-1:0] h_addr = '0, s_addr = '0;
  logic [DW-1:0] h_wdata = '0, s_wdata = '0;

  logic [DW-1:0] h_rd, s_rd, uh_rd, us_rd;
  logic h_gnt, s_gnt, h_den, s_den;
  logic uh_gnt, us_gnt, uh_den, us_den;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_lock_ram #(.DATA_W(DW), .ADDR_W(AW), .LOCKABLE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .hw_en(h_en), .hw_we(h_we), .hw_addr(h_addr), .hw_wdata(h_wdata), .hw_rdata(h_rd),
    .hw_lock_req(h_lreq), .hw_lock_rel(h_lrel), .hw_granted(h_gnt), .hw_denied(h_den),
    .sw_en(s_en), .sw_we(s_we), .sw_addr(s_addr), .sw_wdata(s_wdata), .sw_rdata(s_rd),
    .sw_lock_req(s_lreq), .sw_lock_rel(s_lrel), .sw_granted(s_gnt), .sw_denied(s_den)
  );

  shared_lock_ram #(.DATA_W(DW), .ADDR_W(AW), .LOCKABLE(1'b0)) dut_u (
    .clk(clk), .rst_n(rst_n),
    .hw_en(h_en), .hw_we(h_we), .hw_addr(h_addr), .hw_wdata(h_wdata), .hw_rdata(uh_rd),
    .hw_lock_req(h_lreq), .hw_lock_rel(h_lrel), .hw_granted(uh_gnt), .hw_denied(uh_den),
    .sw_en(s_en), .sw_we(s_we), .sw_addr(s_addr), .sw_wdata(s_wdata), .sw_rdata(us_rd),
    .sw_lock_req(s_lreq), .sw_lock_rel(s_lrel), .sw_granted(us_gnt), .sw_denied(us_den)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    h_en = 0; h_we = 0; h_lreq = 0; h_lrel = 0;
    s_en = 0; s_we = 0; s_lreq = 0; s_lrel = 0;
  endtask

  // one rising edge between stimulus and sample
  task automatic step();
    @(negedge clk);
  endtask

  task automatic hw_acc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    h_en = 1; h_we = we; h_addr = a; h_wdata = d;
  endtask

  task automatic sw_acc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    s_en = 1; s_we = we; s_addr = a; s_wdata = d;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    check("R1", "hw grant", {31'd0, h_gnt}, 0);
    check("R1", "sw grant", {31'd0, s_gnt}, 0);
    check("R1", "hw denied", {31'd0, h_den}, 0);
    check("R1", "sw denied", {31'd0, s_den}, 0);
    check("R1", "hw rdata", h_rd, 0);
    check("R1", "sw rdata", s_rd, 0);
  endtask

  task automatic t_hw_owner();
    h_lreq = 1; step(); idle();
    check("R2", "hw grant after request", {31'd0, h_gnt}, 1);
    check("R2", "sw grant low", {31'd0, s_gnt}, 0);
    hw_acc(1, 6'd3, 32'h1111_0003); step(); idle();
    check("R2", "owner write not denied", {31'd0, h_den}, 0);
    hw_acc(1, 6'd5, 32'h5555_0005); step(); idle();
    hw_acc(0, 6'd3, '0); step(); idle();
    check("R8", "hw read addr3", h_rd, 32'h1111_0003);
    step();
    check("R8", "rdata 0 after no read", h_rd, 0);
  endtask

  task automatic t_sw_blocked();
    s_lreq = 1; sw_acc(1, 6'd5, 32'hDEAD_BEEF); step(); idle();
    check("R7", "sw request dropped", {31'd0, s_gnt}, 0);
    check("R4", "sw write denied", {31'd0, s_den}, 1);
    check("R4", "hw keeps lock", {31'd0, h_gnt}, 1);
    step();
    check("R4", "denied is one cycle", {31'd0, s_den}, 0);
    sw_acc(0, 6'd5, '0); step(); idle();
    check("R4", "sw read denied", {31'd0, s_den}, 1);
    check("R4", "sw read data zero", s_rd, 0);
    s_lrel = 1; step(); idle();
    check("R7", "non-owner release ignored", {31'd0, h_gnt}, 1);
    hw_acc(0, 6'd5, '0); step(); idle();
    check("R4", "refused write left addr5", h_rd, 32'h5555_0005);
    h_lrel = 1; step(); idle();
    check("R2", "hw released", {31'd0, h_gnt}, 0);
    check("R7", "dropped sw request not queued", {31'd0, s_gnt}, 0);
  endtask

  task automatic t_free_denied();
    hw_acc(1, 6'd3, 32'h0BAD_0BAD); step(); idle();
    check("R6", "hw access while free denied", {31'd0, h_den}, 1);
    sw_acc(0, 6'd3, '0); step(); idle();
    check("R6", "sw access while free denied", {31'd0, s_den}, 1);
    check("R6", "sw read data zero", s_rd, 0);
  endtask

  task automatic t_tie();
    h_lreq = 1; s_lreq = 1; step(); idle();
    check("R3", "hw wins tie", {31'd0, h_gnt}, 1);
    check("R3", "sw loses tie", {31'd0, s_gnt}, 0);
    h_lrel = 1; step(); idle();
    check("R2", "lock free again", {31'd0, h_gnt | s_gnt}, 0);
  endtask

  task automatic t_sw_owner();
    s_lreq = 1; step(); idle();
    check("R2", "sw grant", {31'd0, s_gnt}, 1);
    sw_acc(0, 6'd3, '0); step(); idle();
    check("R6", "free-time write had no effect", s_rd, 32'h1111_0003);
    hw_acc(1, 6'd3, 32'hBEEF_0003); step(); idle();
    check("R5", "hw write denied", {31'd0, h_den}, 1);
    hw_acc(0, 6'd3, '0); step(); idle();
    check("R5", "hw read denied", {31'd0, h_den}, 1);
    check("R5", "hw read zero", h_rd, 0);
    h_lrel = 1; step(); idle();
    check("R7", "hw release ignored", {31'd0, s_gnt}, 1);
    sw_acc(1, 6'd7, 32'h7777_0007); step(); idle();
    sw_acc(0, 6'd7, '0); step(); idle();
    check("R8", "sw read addr7", s_rd, 32'h7777_0007);
    sw_acc(0, 6'd3, '0); step(); idle();
    check("R5", "refused hw write left addr3", s_rd, 32'h1111_0003);
    s_lrel = 1; step(); idle();
    check("R2", "sw released", {31'd0, s_gnt}, 0);
  endtask

  task automatic t_unprot();
    h_lreq = 1; s_lreq = 1; hw_acc(1, 6'd9, 32'h0000_00AA); sw_acc(1, 6'd9, 32'h0000_00BB);
    step(); idle();
    check("R9", "open hw grant low", {31'd0, uh_gnt}, 0);
    check("R9", "open sw grant low", {31'd0, us_gnt}, 0);
    check("R9", "open hw not denied", {31'd0, uh_den}, 0);
    check("R9", "open sw not denied", {31'd0, us_den}, 0);
    sw_acc(0, 6'd9, '0); step(); idle();
    check("R10", "hw data wins collision", us_rd, 32'h0000_00AA);
    hw_acc(1, 6'd10, 32'h0000_0001); step(); idle();
    hw_acc(0, 6'd10, '0); sw_acc(1, 6'd10, 32'h0000_0002); step(); idle();
    check("R11", "read sees old word", uh_rd, 32'h0000_0001);
    hw_acc(0, 6'd10, '0); step(); idle();
    check("R9", "sw write landed", uh_rd, 32'h0000_0002);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_hw_owner();
    t_sw_blocked();
    t_free_denied();
    t_tie();
    t_sw_owner();
    t_unprot();
    finished = 1;
    report();
  end
endmodule